// File: doc/BRIEF.md
# Interrupt Table Walker

This block turns an 8-bit interrupt vector into a dispatch decision. It holds a table register with a base address and a byte limit, which software loads through a write port. When a request is accepted, the walker works out where the vector's 8-byte entry starts and checks that the whole entry lies within the limit. If the entry is out of range, the walker faults at once and issues no memory read. If it is in range, the walker fetches the entry as two 32-bit words over a valid/ready read port. It then decodes the gate type and produces exactly one outcome.

There are three outcomes. The first is a dispatch with a handler selector and offset, together with a flag that says whether hardware interrupts must be masked. The second is a task-switch request that carries the task selector. The third is a fault. The surrounding core acts on the outcome. Selector translation, privilege rules, stacks and the task switch itself are handled elsewhere.

The controller is a single state machine with these states:

- `ST_IDLE`: waits for a request.
- `ST_CHECK`: does the range check.
- `ST_REQ_LO`, `ST_WAIT_LO`: request and receive the lower word.
- `ST_REQ_HI`, `ST_WAIT_HI`: request and receive the upper word.
- `ST_DECODE`: decodes the entry.
- `ST_DISPATCH`, `ST_TASK`, `ST_FAULT`: each emits one one-cycle outcome.

The transitions are:

- IDLE→CHECK when a request arrives.
- CHECK→REQ_LO when the entry is in range, CHECK→FAULT when it is not.
- REQ_LO→WAIT_LO and REQ_HI→WAIT_HI on read handshake.
- WAIT_LO→REQ_HI and WAIT_HI→DECODE on read response.
- DECODE→DISPATCH for an interrupt or trap gate, DECODE→TASK for a task gate, DECODE→FAULT for a bad entry.
- Each outcome state returns to IDLE after one cycle.

Top module: `intr_table_walker`

## Requirements
- R1: After reset the table base and limit are 0, req_ready is 1, and no outcome or read request is asserted. A lookup of vector 0 before any table write therefore faults.
- R2: A table write while req_ready is 1 replaces the base and limit from the next cycle; a write in the same cycle as an accepted request is used by that request. A table write while req_ready is 0 is ignored, so later lookups still use the old base.
- R3: A request is accepted only while req_ready is 1. req_ready stays 0 from the cycle after acceptance through the outcome cycle. A request held high during a lookup starts nothing.
- R4: The entry address is base + vector×8, modulo 2^32. The lower word is read at that address and the upper word at address+4. A read request holds its address until rd_req_ready is seen.
- R5: An entry is in range only if vector×8+7 ≤ limit. Otherwise disp_fault pulses 2 cycles after acceptance and no read is requested.
- R6: The entry fields are laid out as follows:
  - Lower word: bits 15:0 are offset[15:0] and bits 31:16 are the selector.
  - Upper word: bit 15 is the present bit, bits 11:8 are the type code, and bits 31:16 are offset[31:16].
  
  A present entry with type 0xE (interrupt gate) pulses disp_done with disp_mask_intr=1 and reports the selector and the 32-bit offset.
- R7: A present entry with type 0xF (trap gate) pulses disp_done with disp_mask_intr=0 and reports the selector and offset.
- R8: A present entry with type 0x5 (task gate) pulses disp_task instead of disp_done, with disp_sel holding the selector.
- R9: A clear present bit, or any type code other than 0x5, 0xE or 0xF, pulses disp_fault.
- R10: Each accepted request produces exactly one of disp_done, disp_task or disp_fault, high for one cycle. For a fetched entry the pulse comes 2 cycles after the clock edge that accepts the upper-word response. req_ready returns the cycle after the pulse.
- R11: Vector 0 is a legal entry and is dispatched like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table register write strobe |
| tbl_wr_base | input | 32 | New table base address |
| tbl_wr_limit | input | 16 | New table limit (last valid byte offset) |
| req_valid | input | 1 | Interrupt request |
| req_vector | input | 8 | Interrupt vector |
| req_ready | output | 1 | Walker idle, request accepted |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts read request |
| rd_addr | output | 32 | Read byte address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data word |
| disp_done | output | 1 | Handler dispatch pulse |
| disp_mask_intr | output | 1 | With disp_done: mask hardware interrupts |
| disp_task | output | 1 | Task switch pulse |
| disp_fault | output | 1 | Fault pulse |
| disp_sel | output | 16 | Handler or task selector |
| disp_off | output | 32 | Handler offset |

## Verification
A range fault is due 2 cycles after the accepting edge. The first read request appears in that same cycle when the entry is in range. The outcome pulse is due 2 cycles after the edge that takes the upper-word response, and req_ready returns one cycle later. The bench acts as the memory: it inserts random handshake and response delays, then steps one falling edge at a time. At each step it checks that the read request and address hold, that no early outcome appears, and that the expected pulse shows in exactly the due cycle and is gone in the next.

// File: rtl/intr_tbl_pkg.sv
package intr_tbl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_REQ_HI,
        ST_WAIT_HI,
        ST_DECODE,
        ST_DISPATCH,
        ST_TASK,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        GK_INTR,
        GK_TRAP,
        GK_TASK,
        GK_BAD
    } gate_kind_e;

    localparam logic [3:0] GT_TASK = 4'h5;
    localparam logic [3:0] GT_INTR = 4'hE;
    localparam logic [3:0] GT_TRAP = 4'hF;

    localparam int SEL_W = 16;
    localparam int OFF_W = 32;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [OFF_W-1:0] off;
        gate_kind_e       kind;
    } gate_info_t;

endpackage

// File: rtl/intr_tbl_reg.sv
module intr_tbl_reg #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_allow,
    input  logic [ADDR_W-1:0]  wr_base,
    input  logic [LIMIT_W-1:0] wr_limit,
    output logic [ADDR_W-1:0]  base,
    output logic [LIMIT_W-1:0] limit
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            limit <= '0;
        end else if (wr_en && wr_allow) begin
            base  <= wr_base;
            limit <= wr_limit;
        end
    end

    // R2: the table register must not move while a lookup is running
    p_hold_when_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> ($stable(base) && $stable(limit)));

endmodule

// File: rtl/intr_bound_chk.sv
module intr_bound_chk #(
    parameter int ADDR_W      = 32,
    parameter int VEC_W       = 8,
    parameter int LIMIT_W     = 16,
    parameter int ENTRY_BYTES = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [LIMIT_W-1:0] limit,
    input  logic [VEC_W-1:0]   vector,
    output logic [ADDR_W-1:0]  entry_addr,
    output logic               in_range
);

    localparam int SHIFT  = $clog2(ENTRY_BYTES);
    localparam int SPAN_W = VEC_W + SHIFT + 1;
    localparam int CMP_W  = (SPAN_W > LIMIT_W) ? SPAN_W : LIMIT_W;

    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] limit_ext;

    always_comb begin
        entry_addr = base + (ADDR_W'(vector) << SHIFT);
        last_byte  = (CMP_W'(vector) << SHIFT) + CMP_W'(ENTRY_BYTES - 1);
        limit_ext  = CMP_W'(limit);
        in_range   = (last_byte <= limit_ext);
    end

endmodule

// File: rtl/intr_gate_decode.sv
module intr_gate_decode
    import intr_tbl_pkg::*;
(
    input  logic [WORD_W-1:0] word_lo,
    input  logic [15:0]       off_hi,
    input  logic              present,
    input  logic [3:0]        type_code,
    output gate_info_t        info
);

    always_comb begin
        info.sel = word_lo[31:16];
        info.off = {off_hi, word_lo[15:0]};
        if (!present) begin
            info.kind = GK_BAD;
        end else begin
            unique case (type_code)
                GT_INTR: info.kind = GK_INTR;
                GT_TRAP: info.kind = GK_TRAP;
                GT_TASK: info.kind = GK_TASK;
                default: info.kind = GK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/intr_table_walker.sv
module intr_table_walker
    import intr_tbl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int VEC_W       = 8,
    parameter int LIMIT_W     = 16,
    parameter int ENTRY_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_wr_en,
    input  logic [ADDR_W-1:0]  tbl_wr_base,
    input  logic [LIMIT_W-1:0] tbl_wr_limit,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   req_vector,
    output logic               req_ready,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_resp_valid,
    input  logic [31:0]        rd_resp_data,
    output logic               disp_done,
    output logic               disp_mask_intr,
    output logic               disp_task,
    output logic               disp_fault,
    output logic [15:0]        disp_sel,
    output logic [31:0]        disp_off
);

    localparam int HI_OFS = ENTRY_BYTES / 2;

    walk_state_e state_q, state_d;

    logic [VEC_W-1:0]   vec_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  lo_q;
    logic [15:0]        off_hi_q;
    logic               present_q;
    logic [3:0]         type_q;
    gate_info_t         info_q;

    logic [ADDR_W-1:0]  tbl_base;
    logic [LIMIT_W-1:0] tbl_limit;
    logic [ADDR_W-1:0]  entry_addr;
    logic               entry_in_range;
    gate_info_t         gate_dec;

    intr_tbl_reg #(
        .ADDR_W  (ADDR_W),
        .LIMIT_W (LIMIT_W)
    ) u_tbl_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_allow (state_q == ST_IDLE),
        .wr_base  (tbl_wr_base),
        .wr_limit (tbl_wr_limit),
        .base     (tbl_base),
        .limit    (tbl_limit)
    );

    intr_bound_chk #(
        .ADDR_W      (ADDR_W),
        .VEC_W       (VEC_W),
        .LIMIT_W     (LIMIT_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_bound_chk (
        .base       (tbl_base),
        .limit      (tbl_limit),
        .vector     (vec_q),
        .entry_addr (entry_addr),
        .in_range   (entry_in_range)
    );

    intr_gate_decode u_gate_decode (
        .word_lo   (lo_q),
        .off_hi    (off_hi_q),
        .present   (present_q),
        .type_code (type_q),
        .info      (gate_dec)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_CHECK;
            ST_CHECK:    state_d = entry_in_range ? ST_REQ_LO : ST_FAULT;
            ST_REQ_LO:   if (rd_req_ready) state_d = ST_WAIT_LO;
            ST_WAIT_LO:  if (rd_resp_valid) state_d = ST_REQ_HI;
            ST_REQ_HI:   if (rd_req_ready) state_d = ST_WAIT_HI;
            ST_WAIT_HI:  if (rd_resp_valid) state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (gate_dec.kind)
                    GK_INTR, GK_TRAP: state_d = ST_DISPATCH;
                    GK_TASK:          state_d = ST_TASK;
                    default:          state_d = ST_FAULT;
                endcase
            end
            ST_DISPATCH, ST_TASK, ST_FAULT: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q     <= '0;
            addr_q    <= '0;
            lo_q      <= '0;
            off_hi_q  <= '0;
            present_q <= 1'b0;
            type_q    <= '0;
            info_q    <= '{sel: '0, off: '0, kind: GK_BAD};
        end else begin
            if (state_q == ST_IDLE && req_valid) vec_q <= req_vector;
            if (state_q == ST_CHECK) addr_q <= entry_addr;
            if (state_q == ST_WAIT_LO && rd_resp_valid) lo_q <= rd_resp_data;
            if (state_q == ST_WAIT_HI && rd_resp_valid) begin
                off_hi_q  <= rd_resp_data[31:16];
                present_q <= rd_resp_data[15];
                type_q    <= rd_resp_data[11:8];
            end
            if (state_q == ST_DECODE) info_q <= gate_dec;
        end
    end

    // Outputs
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        rd_req_valid   = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
        rd_addr        = (state_q == ST_REQ_HI) ? addr_q + ADDR_W'(HI_OFS) : addr_q;
        disp_done      = (state_q == ST_DISPATCH);
        disp_mask_intr = (state_q == ST_DISPATCH) && (info_q.kind == GK_INTR);
        disp_task      = (state_q == ST_TASK);
        disp_fault     = (state_q == ST_FAULT);
        disp_sel       = info_q.sel;
        disp_off       = info_q.off;
    end

    // R3: an accepted request makes the walker busy in the next cycle
    p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4: a stalled read request keeps its address
    p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

    // R5: an out-of-range entry faults without any read
    p_limit_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !entry_in_range) |=> (disp_fault && !rd_req_valid));

    // R6: masking is only reported with a dispatch
    p_mask_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_mask_intr |-> disp_done);

    // R9: a bad entry ends in a fault
    p_bad_entry_faults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && gate_dec.kind == GK_BAD) |=> disp_fault);

    // R10: an outcome lasts one cycle and the walker is then idle
    p_outcome_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_done || disp_task || disp_fault) |=>
            (!(disp_done || disp_task || disp_fault) && req_ready));

    // R10: never more than one outcome at a time
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({disp_done, disp_task, disp_fault}) <= 1);

endmodule

// File: tb/intr_table_walker_bench.sv
module intr_table_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tbl_wr_en;
    logic [31:0] tbl_wr_base;
    logic [15:0] tbl_wr_limit;
    logic        req_valid;
    logic [7:0]  req_vector;
    logic        req_ready;
    logic        rd_req_valid;
    logic        rd_req_ready;
    logic [31:0] rd_addr;
    logic        rd_resp_valid;
    logic [31:0] rd_resp_data;
    logic        disp_done;
    logic        disp_mask_intr;
    logic        disp_task;
    logic        disp_fault;
    logic [15:0] disp_sel;
    logic [31:0] disp_off;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mem_lo [256];
    logic [31:0] mem_hi [256];
    logic [31:0] cur_base;
    logic [15:0] cur_limit;

    always #2 clk = ~clk;

    intr_table_walker u_intr_table_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .tbl_wr_en      (tbl_wr_en),
        .tbl_wr_base    (tbl_wr_base),
        .tbl_wr_limit   (tbl_wr_limit),
        .req_valid      (req_valid),
        .req_vector     (req_vector),
        .req_ready      (req_ready),
        .rd_req_valid   (rd_req_valid),
        .rd_req_ready   (rd_req_ready),
        .rd_addr        (rd_addr),
        .rd_resp_valid  (rd_resp_valid),
        .rd_resp_data   (rd_resp_data),
        .disp_done      (disp_done),
        .disp_mask_intr (disp_mask_intr),
        .disp_task      (disp_task),
        .disp_fault     (disp_fault),
        .disp_sel       (disp_sel),
        .disp_off       (disp_off)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk_lo(input logic [15:0] sel, input logic [15:0] off_lo);
        return {sel, off_lo};
    endfunction

    function automatic logic [31:0] mk_hi(input bit present, input logic [3:0] typ, input logic [15:0] off_hi);
        return {off_hi, present, 3'b000, typ, 8'h00};
    endfunction

    function automatic bit fn_in_range(input int vec, input logic [15:0] lim);
        return (vec * 8 + 7) <= int'(lim);
    endfunction

    // 0 interrupt gate, 1 trap gate, 2 task gate, 3 fault
    function automatic int fn_kind(input logic [31:0] hi);
        if (!hi[15]) return 3;
        case (hi[11:8])
            4'hE:    return 0;
            4'hF:    return 1;
            4'h5:    return 2;
            default: return 3;
        endcase
    endfunction

    function automatic bit no_outcome();
        return !(disp_done || disp_task || disp_fault);
    endfunction

    task automatic tbl_write(input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        tbl_wr_en    = 1'b1;
        tbl_wr_base  = b;
        tbl_wr_limit = l;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        cur_base  = b;
        cur_limit = l;
    endtask

    task automatic do_lookup(input int vec, input bit busy_poke, input string addr_tag);
        logic [31:0] exp_addr;
        int kind;
        exp_addr = cur_base + 32'(vec * 8);
        kind = fn_kind(mem_hi[vec]);
        @(negedge clk);
        chk(req_ready === 1'b1, "R3", 64'(req_ready), 64'd1);
        req_valid  = 1'b1;
        req_vector = 8'(vec);
        @(negedge clk);
        req_valid = 1'b0;
        // now in the check cycle
        chk(req_ready == 1'b0, "R3", 64'(req_ready), 64'd0);
        chk(rd_req_valid == 1'b0, "R5", 64'(rd_req_valid), 64'd0);
        if (busy_poke) begin
            // R2 and R3: a write and a fresh request while busy are ignored
            tbl_wr_en    = 1'b1;
            tbl_wr_base  = $urandom;
            tbl_wr_limit = 16'($urandom);
            req_valid    = 1'b1;
            req_vector   = 8'($urandom);
        end
        @(negedge clk);
        tbl_wr_en = 1'b0;
        req_valid = 1'b0;
        if (!fn_in_range(vec, cur_limit)) begin
            chk(disp_fault == 1'b1, "R5", 64'(disp_fault), 64'd1);
            chk(rd_req_valid == 1'b0, "R5", 64'(rd_req_valid), 64'd0);
            chk(!disp_done && !disp_task, "R10", 64'({disp_done, disp_task}), 64'd0);
            @(negedge clk);
            chk(no_outcome() && req_ready, "R10", 64'({disp_done, disp_task, disp_fault, req_ready}), 64'd1);
            return;
        end
        for (int w = 0; w < 2; w++) begin
            int dly;
            logic [31:0] wa;
            wa  = exp_addr + 32'(4 * w);
            dly = $urandom % 3;
            repeat (dly) begin
                chk(rd_req_valid && rd_addr == wa, "R4", 64'(rd_addr), 64'(wa));
                @(negedge clk);
            end
            chk(rd_req_valid == 1'b1, "R4", 64'(rd_req_valid), 64'd1);
            chk(rd_addr == wa, addr_tag, 64'(rd_addr), 64'(wa));
            rd_req_ready = 1'b1;
            @(negedge clk);
            rd_req_ready = 1'b0;
            dly = $urandom % 3;
            repeat (dly) begin
                chk(!rd_req_valid && no_outcome(), "R10", 64'({rd_req_valid, disp_done, disp_task, disp_fault}), 64'd0);
                @(negedge clk);
            end
            rd_resp_valid = 1'b1;
            rd_resp_data  = (w == 0) ? mem_lo[vec] : mem_hi[vec];
            @(negedge clk);
            rd_resp_valid = 1'b0;
        end
        // decode cycle: nothing yet
        chk(no_outcome(), "R10", 64'({disp_done, disp_task, disp_fault}), 64'd0);
        @(negedge clk);
        case (kind)
            0: begin
                chk(disp_done == 1'b1, "R6", 64'(disp_done), 64'd1);
                chk(disp_mask_intr == 1'b1, "R6", 64'(disp_mask_intr), 64'd1);
                chk(disp_sel == mem_lo[vec][31:16], "R6", 64'(disp_sel), 64'(mem_lo[vec][31:16]));
                chk(disp_off == {mem_hi[vec][31:16], mem_lo[vec][15:0]}, "R6", 64'(disp_off),
                    64'({mem_hi[vec][31:16], mem_lo[vec][15:0]}));
                chk(!disp_task && !disp_fault, "R10", 64'({disp_task, disp_fault}), 64'd0);
            end
            1: begin
                chk(disp_done == 1'b1, "R7", 64'(disp_done), 64'd1);
                chk(disp_mask_intr == 1'b0, "R7", 64'(disp_mask_intr), 64'd0);
                chk(disp_sel == mem_lo[vec][31:16], "R7", 64'(disp_sel), 64'(mem_lo[vec][31:16]));
                chk(disp_off == {mem_hi[vec][31:16], mem_lo[vec][15:0]}, "R7", 64'(disp_off),
                    64'({mem_hi[vec][31:16], mem_lo[vec][15:0]}));
                chk(!disp_task && !disp_fault, "R10", 64'({disp_task, disp_fault}), 64'd0);
            end
            2: begin
                chk(disp_task == 1'b1, "R8", 64'(disp_task), 64'd1);
                chk(disp_done == 1'b0, "R8", 64'(disp_done), 64'd0);
                chk(disp_sel == mem_lo[vec][31:16], "R8", 64'(disp_sel), 64'(mem_lo[vec][31:16]));
            end
            default: begin
                chk(disp_fault == 1'b1, "R9", 64'(disp_fault), 64'd1);
                chk(!disp_done && !disp_task, "R9", 64'({disp_done, disp_task}), 64'd0);
            end
        endcase
        if (vec == 0 && kind != 3) begin
            chk(disp_fault == 1'b0, "R11", 64'(disp_fault), 64'd0);
        end
        @(negedge clk);
        chk(no_outcome() && req_ready && !rd_req_valid, "R10",
            64'({disp_done, disp_task, disp_fault, req_ready, rd_req_valid}), 64'b00010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n         = 1'b0;
        tbl_wr_en     = 1'b0;
        tbl_wr_base   = '0;
        tbl_wr_limit  = '0;
        req_valid     = 1'b0;
        req_vector    = '0;
        rd_req_ready  = 1'b0;
        rd_resp_valid = 1'b0;
        rd_resp_data  = '0;
        cur_base      = '0;
        cur_limit     = '0;
        for (int v = 0; v < 256; v++) begin
            logic [3:0] typ;
            int pick;
            pick = $urandom % 6;
            case (pick)
                0:       typ = 4'h5;
                1, 3:    typ = 4'hE;
                2, 4:    typ = 4'hF;
                default: typ = 4'($urandom);
            endcase
            mem_lo[v] = mk_lo(16'($urandom), 16'($urandom));
            mem_hi[v] = mk_hi(($urandom % 8) != 0, typ, 16'($urandom));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1);
        chk(no_outcome(), "R1", 64'({disp_done, disp_task, disp_fault}), 64'd0);
        chk(rd_req_valid == 1'b0, "R1", 64'(rd_req_valid), 64'd0);
        // R1: limit 0 after reset, so vector 0 faults
        do_lookup(0, 1'b0, "R1");

        // Directed gate types
        mem_lo[0] = mk_lo(16'h0010, 16'h1234);
        mem_hi[0] = mk_hi(1'b1, 4'hE, 16'hC000);
        mem_lo[1] = mk_lo(16'h0018, 16'hBEEF);
        mem_hi[1] = mk_hi(1'b1, 4'hF, 16'h0000);
        mem_lo[2] = mk_lo(16'h0028, 16'h0000);
        mem_hi[2] = mk_hi(1'b1, 4'h5, 16'h0000);
        mem_lo[3] = mk_lo(16'h0010, 16'h5555);
        mem_hi[3] = mk_hi(1'b0, 4'hE, 16'h0000);
        mem_lo[4] = mk_lo(16'h0010, 16'h6666);
        mem_hi[4] = mk_hi(1'b1, 4'hC, 16'h0000);
        mem_lo[9] = mk_lo(16'h0030, 16'h0009);
        mem_hi[9] = mk_hi(1'b1, 4'hF, 16'h0001);
        mem_lo[10] = mk_lo(16'h0038, 16'h000A);
        mem_hi[10] = mk_hi(1'b1, 4'hE, 16'h0002);

        tbl_write(32'h0001_0000, 16'h07FF);
        do_lookup(0, 1'b0, "R2");   // R11 and R6
        do_lookup(1, 1'b0, "R4");   // R7
        do_lookup(2, 1'b0, "R4");   // R8
        do_lookup(3, 1'b0, "R4");   // R9 not present
        do_lookup(4, 1'b0, "R4");   // R9 unknown type
        do_lookup(255, 1'b0, "R4"); // last entry of a full table

        // R5: limit boundary, vector 10 is the last in range
        tbl_write(32'h0002_0040, 16'd87);
        do_lookup(10, 1'b0, "R5");
        do_lookup(11, 1'b0, "R5");
        tbl_write(32'h0002_0040, 16'd86);
        do_lookup(10, 1'b0, "R5");

        // R2/R3: write and request while busy are ignored
        tbl_write(32'h0003_0000, 16'h07FF);
        do_lookup(3, 1'b1, "R2");
        do_lookup(9, 1'b0, "R2");

        // R4: address wraps modulo 2^32
        tbl_write(32'hFFFF_FFF0, 16'h07FF);
        do_lookup(4, 1'b0, "R4");
        do_lookup(2, 1'b0, "R4");

        // Constrained random
        for (int i = 0; i < 150; i++) begin
            if ($urandom % 10 == 0) begin
                logic [15:0] lim;
                lim = ($urandom % 2) ? 16'h07FF : 16'($urandom % 2304);
                tbl_write($urandom, lim);
            end
            do_lookup($urandom % 256, ($urandom % 8) == 0, "R4");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule